// File: doc/BRIEF.md
# Clock-Recovery Reference/Data Lock Controller

This block is the digital supervisor beside a clock-recovery loop. It decides whether the loop is steered toward the local reference clock or toward the incoming serial data. It measures the recovered parallel clock against the reference. A free-running counter in the recovered-clock domain is sampled in Gray code every 2^WIN_LOG2 reference cycles, and the count difference is compared with the count the selected rate and reference imply. The block also watches two loss indications: the optical module's signal-present input and an internal loss-of-signal flag.

After reset the loop is held on the reference. Two consecutive measurement windows within tolerance, with no loss indication, move it to data tracking. A window out of tolerance, or any loss indication, sends it straight back to the reference, so a receive clock is always produced downstream. The steering select lives in the reference domain. A lock flag that follows it is resynchronised into the system clock domain. The reference clock mux itself is outside this block. The selects describe which reference is in use and must only change while reset is held.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: While `rst_n` is low, `track_data` and `locked` are 0 (0 = steer to reference, 1 = steer to data).
- R2: Each window counts `rec_clk` rising edges over 2^WIN_LOG2 `ref_clk` cycles. The expected count is 2^WIN_LOG2 times rec/ref. The recovered parallel clock is 77.76 MHz when `rate_sel`=1 and 19.44 MHz when 0. The reference is 19.44 MHz when `ref_src_sel`=0 and `ref_freq_sel`=1, and 77.76 MHz otherwise. The first window after reset is discarded.
- R3: A window is in tolerance when |count − expected| ≤ expected >> TOL_SHIFT. The default TOL_SHIFT of 11 gives about 488 ppm.
- R4: Moving from reference to data needs two consecutive in-tolerance windows with no loss indication. A single good window is not enough, and `track_data` changes only at a window end or on loss.
- R5: While tracking data, an out-of-tolerance window returns the loop to the reference at the end of that window.
- R6: `sig_present` low or `los_int` high returns the loop to the reference within a few reference cycles, whatever the frequency.
- R7: While a loss indication is held, the loop stays on the reference. After it clears, two fresh in-tolerance windows are needed again.
- R8: A recovered clock at a rate other than the one the selects imply never reaches data tracking.
- R9: `locked` is `track_data` passed through a two-stage synchroniser on `clk`. It is high only while data is tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the lock flag |
| ref_clk | input | 1 | Selected local reference clock |
| rec_clk | input | 1 | Recovered clock divided to the parallel rate |
| rst_n | input | 1 | Synchronous active-low reset, all domains |
| rate_sel | input | 1 | 1 = 622.08 Mbps line, 0 = 155.52 Mbps |
| ref_src_sel | input | 1 | 1 = auxiliary 77.76 MHz reference, 0 = synthesizer reference |
| ref_freq_sel | input | 1 | Synthesizer reference: 1 = 19.44 MHz, 0 = 77.76 MHz |
| sig_present | input | 1 | Optical module signal detect, high = signal present |
| los_int | input | 1 | Internal loss-of-signal, high = declared |
| track_data | output | 1 | Loop steering select, 1 = data |
| locked | output | 1 | Lock flag in the `clk` domain |

## Verification
A corrupt window count or a wrong expected ratio shows up as a lock that never comes, or one that comes at the wrong offset. It becomes visible at the ports by the third window after reset. A hysteresis counter that is not cleared by loss shows up as a return to data one window early after a loss episode. A broken loss path leaves `track_data` high for more than a few reference cycles after `sig_present` drops. Each of these is sampled at times chosen from the window length, with margin on both sides of every window end.

// File: rtl/cdr_lock_pkg.sv
// Shared types and helpers for the clock-recovery lock controller.
package cdr_lock_pkg;

    // Steering state of the recovery loop.
    typedef enum logic {
        ST_REF  = 1'b0,
        ST_DATA = 1'b1
    } loop_state_t;

    // Recovered-parallel-clock to reference-clock frequency ratio.
    typedef enum logic [1:0] {
        RATIO_EQ = 2'd0,
        RATIO_X4 = 2'd1,
        RATIO_D4 = 2'd2
    } ratio_t;

    // Derive the ratio from the rate and reference selects.
    function automatic ratio_t ratio_of(input logic rate_sel,
                                        input logic ref_src_sel,
                                        input logic ref_freq_sel);
        logic slow_ref;
        slow_ref = !ref_src_sel && ref_freq_sel;
        if (rate_sel && slow_ref)
            return RATIO_X4;
        else if (!rate_sel && !slow_ref)
            return RATIO_D4;
        else
            return RATIO_EQ;
    endfunction

endpackage

// File: rtl/cdr_sync2.sv
// Two-stage synchroniser.
// Assumes: multi-bit use only for Gray-coded values, where one bit moves at a time.
module cdr_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two flops in series into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cdr_gray_count.sv
// Free-running Gray-coded edge counter in the recovered-clock domain.
// Assumes: rst_n is held for several recovered-clock cycles.
module cdr_gray_count #(
    parameter int CW = 20
) (
    input  logic          rec_clk,
    input  logic          rst_n,
    output logic [CW-1:0] gray
);
    logic [CW-1:0] bin;
    logic [CW-1:0] bin_nx;

    assign bin_nx = bin + 1'b1;

    // Count every edge and register its Gray image.
    always_ff @(posedge rec_clk) begin
        if (!rst_n) begin
            bin  <= '0;
            gray <= '0;
        end else begin
            bin  <= bin_nx;
            gray <= bin_nx ^ (bin_nx >> 1);
        end
    end
endmodule

// File: rtl/cdr_freq_meter.sv
// Window frequency meter. Samples the recovered-edge count once every
// 2^WIN_LOG2 reference cycles and flags whether the difference lies within
// expected >> TOL_SHIFT of the expected count.
// Assumes: WIN_LOG2 >= 2 and the ratio is static outside reset.
module cdr_freq_meter
    import cdr_lock_pkg::*;
#(
    parameter int WIN_LOG2  = 16,
    parameter int TOL_SHIFT = 11,
    parameter int CW        = WIN_LOG2 + 4
) (
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic [CW-1:0] gray_in,
    input  ratio_t        ratio,
    output logic          win_end,
    output logic          win_ok
);
    localparam logic [WIN_LOG2-1:0] WIN_LAST = {WIN_LOG2{1'b1}};

    logic [WIN_LOG2-1:0] win_cnt;
    logic [CW-1:0]       g_sync;
    logic [CW-1:0]       rec_bin;
    logic [CW-1:0]       prev_bin;
    logic [CW-1:0]       delta;
    logic [CW-1:0]       expected;
    logic [CW-1:0]       tol;
    logic [CW-1:0]       err;
    logic                primed;

    cdr_sync2 #(.W(CW)) i_gsync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (gray_in),
        .q     (g_sync)
    );

    // Gray to binary, one XOR reduction per bit.
    for (genvar b = 0; b < CW; b++) begin : g_dec
        assign rec_bin[b] = ^g_sync[CW-1:b];
    end

    // Expected count, tolerance and absolute error of the current window.
    always_comb begin
        case (ratio)
            RATIO_X4: expected = CW'(1) << (WIN_LOG2 + 2);
            RATIO_D4: expected = CW'(1) << (WIN_LOG2 - 2);
            default:  expected = CW'(1) << WIN_LOG2;
        endcase
        tol   = expected >> TOL_SHIFT;
        delta = rec_bin - prev_bin;
        err   = (delta >= expected) ? (delta - expected) : (expected - delta);
    end

    // Window timing, snapshot and verdict.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            prev_bin <= '0;
            primed   <= 1'b0;
            win_end  <= 1'b0;
            win_ok   <= 1'b0;
        end else begin
            win_cnt <= win_cnt + 1'b1;
            win_end <= 1'b0;
            if (win_cnt == WIN_LAST) begin
                prev_bin <= rec_bin;
                primed   <= 1'b1;
                win_end  <= primed;
                win_ok   <= (err <= tol);
            end
        end
    end
endmodule

// File: rtl/cdr_lock_fsm.sv
// Two-state acquire/track controller. Loss forces reference at once;
// entry to data needs two consecutive good windows.
// Assumes: win_end is a one-cycle pulse with win_ok valid alongside.
module cdr_lock_fsm
    import cdr_lock_pkg::*;
(
    input  logic ref_clk,
    input  logic rst_n,
    input  logic loss_seen,
    input  logic win_end,
    input  logic win_ok,
    output logic track_data
);
    loop_state_t state;
    logic        one_good;

    // State and hysteresis update.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            state    <= ST_REF;
            one_good <= 1'b0;
        end else if (loss_seen) begin
            state    <= ST_REF;
            one_good <= 1'b0;
        end else if (win_end) begin
            case (state)
                ST_REF: begin
                    if (win_ok && one_good) begin
                        state    <= ST_DATA;
                        one_good <= 1'b0;
                    end else begin
                        one_good <= win_ok;
                    end
                end
                default: begin
                    if (!win_ok)
                        state <= ST_REF;
                end
            endcase
        end
    end

    assign track_data = (state == ST_DATA);
endmodule

// File: rtl/cdr_lock_ctrl.sv
// Lock controller top: Gray counter on the recovered clock, window meter and
// FSM on the reference clock, lock flag resynchronised onto the system clock.
// Assumes: selects change only under reset; rst_n spans all three clocks.
module cdr_lock_ctrl
    import cdr_lock_pkg::*;
#(
    parameter int WIN_LOG2  = 16,
    parameter int TOL_SHIFT = 11
) (
    input  logic clk,
    input  logic ref_clk,
    input  logic rec_clk,
    input  logic rst_n,
    input  logic rate_sel,
    input  logic ref_src_sel,
    input  logic ref_freq_sel,
    input  logic sig_present,
    input  logic los_int,
    output logic track_data,
    output logic locked
);
    localparam int CW = WIN_LOG2 + 4;

    logic [CW-1:0] rec_gray;
    logic [1:0]    loss_raw;
    logic [1:0]    loss_sync;
    logic          loss_seen;
    logic          win_end;
    logic          win_ok;
    ratio_t        ratio;

    assign ratio    = ratio_of(rate_sel, ref_src_sel, ref_freq_sel);
    assign loss_raw = {~sig_present, los_int};

    cdr_gray_count #(.CW(CW)) i_cnt (
        .rec_clk (rec_clk),
        .rst_n   (rst_n),
        .gray    (rec_gray)
    );

    cdr_freq_meter #(.WIN_LOG2(WIN_LOG2), .TOL_SHIFT(TOL_SHIFT), .CW(CW)) i_meter (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .gray_in (rec_gray),
        .ratio   (ratio),
        .win_end (win_end),
        .win_ok  (win_ok)
    );

    cdr_sync2 #(.W(2)) i_loss_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (loss_raw),
        .q     (loss_sync)
    );

    assign loss_seen = |loss_sync;

    cdr_lock_fsm i_fsm (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .loss_seen  (loss_seen),
        .win_end    (win_end),
        .win_ok     (win_ok),
        .track_data (track_data)
    );

    cdr_sync2 #(.W(1)) i_lock_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (track_data),
        .q     (locked)
    );
endmodule

// File: rtl/cdr_lock_ctrl_chk.sv
// Property checker for the lock controller, bound into the top.
module cdr_lock_ctrl_chk (
    input logic ref_clk,
    input logic rst_n,
    input logic track_data,
    input logic loss_seen,
    input logic win_end,
    input logic win_ok
);
    // R4: entry to data only on a good window end with no loss
    a_r4_entry_on_good_window: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(track_data) |-> $past(win_end && win_ok && !loss_seen));

    // R4: the select holds between window ends when no loss is seen
    a_r4_hold_between_windows: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!win_end && !loss_seen) |=> $stable(track_data));

    // R5: a bad window while tracking returns to reference
    a_r5_bad_window_exit: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (track_data && win_end && !win_ok) |=> !track_data);

    // R6: any loss indication forces reference on the next edge
    a_r6_loss_forces_ref: assert property (@(posedge ref_clk) disable iff (!rst_n)
        loss_seen |=> !track_data);

    // R7: loss held over two edges keeps reference
    a_r7_no_entry_under_loss: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (loss_seen && $past(loss_seen)) |-> !track_data);
endmodule

bind cdr_lock_ctrl cdr_lock_ctrl_chk i_chk (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .track_data (track_data),
    .loss_seen  (loss_seen),
    .win_end    (win_end),
    .win_ok     (win_ok)
);

// File: tb/test_cdr_lock_ctrl.sv
`timescale 1ns/1ps
module test_cdr_lock_ctrl;
    import cdr_lock_pkg::*;

    localparam int WIN_LOG2  = 10;
    localparam int TOL_SHIFT = 5;
    localparam int WCLK      = (1 << WIN_LOG2) * 2;   // window length in clk cycles (ref 10 ns, clk 5 ns)

    logic clk = 1'b0;
    logic ref_clk = 1'b0;
    logic rec_clk = 1'b0;
    logic rst_n = 1'b0;
    logic rate_sel = 1'b1;
    logic ref_src_sel = 1'b0;
    logic ref_freq_sel = 1'b0;
    logic sig_present = 1'b1;
    logic los_int = 1'b0;
    logic track_data;
    logic locked;
    realtime rec_half = 5.0;

    int n_chk = 0;
    int n_fail = 0;

    cdr_lock_ctrl #(.WIN_LOG2(WIN_LOG2), .TOL_SHIFT(TOL_SHIFT)) i_cdr_lock_ctrl (
        .clk          (clk),
        .ref_clk      (ref_clk),
        .rec_clk      (rec_clk),
        .rst_n        (rst_n),
        .rate_sel     (rate_sel),
        .ref_src_sel  (ref_src_sel),
        .ref_freq_sel (ref_freq_sel),
        .sig_present  (sig_present),
        .los_int      (los_int),
        .track_data   (track_data),
        .locked       (locked)
    );

    initial forever #2.5 clk = ~clk;
    initial forever #5.0 ref_clk = ~ref_clk;
    initial forever #(rec_half) rec_clk = ~rec_clk;

    // Ratio from the R2 table, written independently of the design.
    function automatic int mode_ratio(input logic rs, input logic src, input logic fs);
        real rec_mhz;
        real ref_mhz;
        rec_mhz = rs ? 77.76 : 19.44;
        ref_mhz = (!src && fs) ? 19.44 : 77.76;
        if (rec_mhz > ref_mhz * 2.0) return 1;
        if (rec_mhz * 2.0 < ref_mhz) return 2;
        return 0;
    endfunction

    // Expected lock for a recovered clock of ratio code rc at ppm offset (R3, R8).
    function automatic logic expect_lock(input int mc, input int rc, input int ppm);
        real tol_ppm;
        int  a;
        tol_ppm = 1.0e6 / real'(1 << TOL_SHIFT);
        a = (ppm < 0) ? -ppm : ppm;
        return (mc == rc) && (real'(a) < 0.8 * tol_ppm);
    endfunction

    task automatic set_rec(input int rc, input int ppm);
        real base;
        base = (rc == 1) ? 2.5 : ((rc == 2) ? 40.0 : 10.0);
        rec_half = base / 2.0 / (1.0 + real'(ppm) / 1.0e6);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic do_reset(input logic rs, input logic src, input logic fs);
        rst_n = 1'b0;
        rate_sel = rs;
        ref_src_sel = src;
        ref_freq_sel = fs;
        sig_present = 1'b1;
        los_int = 1'b0;
        wait_clk(60);
        chk("R1 reset track_data", track_data, 1'b0);
        chk("R1 reset locked", locked, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1c3d_5a01));
        wait_clk(2);

        // R1 R2 R4 R9: equal-rate lock only after the third window end
        set_rec(0, 0);
        do_reset(1'b1, 1'b0, 1'b0);
        wait_clk(WCLK * 5 / 2);
        chk("R4 one good window", locked, 1'b0);
        wait_clk(WCLK);
        chk("R2 lock equal ratio", track_data, 1'b1);
        chk("R9 locked follows", locked, 1'b1);

        // R6 R7: signal detect drop
        sig_present = 1'b0;
        wait_clk(20);
        chk("R6 sd loss exit", track_data, 1'b0);
        chk("R9 locked clears", locked, 1'b0);
        wait_clk(WCLK * 3);
        chk("R7 held loss", track_data, 1'b0);
        sig_present = 1'b1;
        wait_clk(WCLK * 9 / 10);
        chk("R7 needs two fresh windows", track_data, 1'b0);
        wait_clk(WCLK * 13 / 10);
        chk("R7 relock after loss", locked, 1'b1);

        // R6: internal loss
        los_int = 1'b1;
        wait_clk(20);
        chk("R6 internal los exit", track_data, 1'b0);
        los_int = 1'b0;
        wait_clk(WCLK * 22 / 10);
        chk("R7 relock after internal los", locked, 1'b1);

        // R5: frequency step while tracking
        set_rec(0, 80000);
        wait_clk(WCLK * 21 / 10);
        chk("R5 off-frequency exit", track_data, 1'b0);
        set_rec(0, 0);
        wait_clk(WCLK * 32 / 10);
        chk("R5 relock after step", locked, 1'b1);

        // R3: tolerance edges
        set_rec(0, 20000);
        do_reset(1'b1, 1'b0, 1'b0);
        wait_clk(WCLK * 36 / 10);
        chk("R3 inside tolerance", locked, 1'b1);
        set_rec(0, -50000);
        do_reset(1'b1, 1'b0, 1'b0);
        wait_clk(WCLK * 5);
        chk("R3 outside tolerance", locked, 1'b0);

        // R2 R8: ratio selection
        set_rec(1, 0);
        do_reset(1'b1, 1'b0, 1'b1);
        wait_clk(WCLK * 36 / 10);
        chk("R2 ratio x4 lock", locked, 1'b1);
        set_rec(2, 0);
        do_reset(1'b0, 1'b1, 1'b0);
        wait_clk(WCLK * 36 / 10);
        chk("R2 ratio 1/4 lock", locked, 1'b1);
        set_rec(0, 0);
        do_reset(1'b0, 1'b0, 1'b1);
        wait_clk(WCLK * 36 / 10);
        chk("R2 slow ref equal lock", locked, 1'b1);
        set_rec(0, 0);
        do_reset(1'b1, 1'b0, 1'b1);
        wait_clk(WCLK * 36 / 10);
        chk("R8 wrong ratio no lock", locked, 1'b0);

        // R3 R8: random modes and offsets
        for (int t = 0; t < 5; t++) begin
            logic rs;
            logic src;
            logic fs;
            int   mc;
            int   rc;
            int   ppm;
            rs  = 1'($urandom_range(1, 0));
            src = 1'($urandom_range(1, 0));
            fs  = 1'($urandom_range(1, 0));
            mc  = mode_ratio(rs, src, fs);
            rc  = ($urandom_range(3, 0) == 0) ? int'($urandom_range(2, 0)) : mc;
            if ($urandom_range(1, 0) == 1)
                ppm = int'($urandom_range(40000, 0)) - 20000;
            else
                ppm = ($urandom_range(1, 0) == 1 ? 1 : -1) * int'($urandom_range(90000, 45000));
            set_rec(rc, ppm);
            do_reset(rs, src, fs);
            wait_clk(WCLK * 36 / 10);
            chk("R3 R8 random trial", locked, expect_lock(mc, rc, ppm));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule